// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns one packed configuration word into the quantum and segment timing of a CAN bit. A prescaler divides the system clock into time quanta. A segment sequencer then steps through a one-quantum synchronization segment, timing segment 1 and timing segment 2. It raises a sample strobe at the end of segment 1 and a bit-start strobe when a new bit begins. The receive line is sampled either once at the sample point or three times, with a majority vote over the sample-point quantum and the two quanta before it.

While `run_en` is low, the unit is in configuration mode. The word on `cfg_word` is captured every clock, and the prescaler and sequencer are held at the start of the synchronization segment. While `run_en` is high, the captured configuration is frozen and timing runs. A `hard_sync` pulse restarts the bit at once. When `resync_en` is high, a recessive-to-dominant edge on the receive line outside the synchronization segment moves the bit boundary. It does so once per bit, by at most the jump width. Frame decoding belongs to the consumer of the strobes.

Top module: `can_bit_timer`

## Requirements
- R1: Bits 9:0 of the configuration word hold the prescaler minus one. One quantum lasts (field + 1) clocks, over a field range of 0 to 63.
- R2: Bits 19:16 hold segment 1 minus one (1 to 16 quanta) and bits 22:20 hold segment 2 minus one (1 to 8 quanta). With no synchronization events, bit_start_stb pulses for one clock every (1 + T1 + T2) quanta.
- R3: sample_stb pulses (1 + T1) quanta after each bit_start_stb pulse.
- R4: With bit 23 clear, bit_val takes the registered receive line value at the sample-point quantum. The receive line passes through one register inside the block.
- R5: With bit 23 set, bit_val takes the majority of the line values at the sample-point quantum and at the two quantum boundaries before it.
- R6: The configuration is captured only while run_en is low. A change of cfg_word while run_en is high does not alter the timing.
- R7: While run_en is low, sample_stb and bit_start_stb stay low.
- R8: A hard_sync pulse sampled while running gives bit_start_stb on the next clock and restarts the bit. The following sample_stb comes (1 + T1) quanta later.
- R9: Bits 15:14 hold the jump width minus one (SJW 1 to 4). A falling receive-line edge in segment 1 lengthens segment 1 by min(e, SJW), where e is the number of segment-1 quanta elapsed, counting the current one. The edge is acted on two clocks after the line changes.
- R10: A falling edge in segment 2 at quantum index q (from 0) shortens segment 2 by min(T2 - q, SJW).
- R11: A falling edge in the synchronization segment, an edge while resync_en is low, and any edge after the first adjustment in a bit leave the timing unchanged.
- R12: bit_val changes only in a clock where sample_stb is high, and sample_stb and bit_start_stb never pulse together.
- R13: After reset, sample_stb and bit_start_stb are low and bit_val is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Low: capture configuration and hold timing; high: run |
| cfg_word | input | 24 | Packed timing configuration |
| rx_line | input | 1 | Receive line, 1 recessive, 0 dominant |
| hard_sync | input | 1 | Restart the current bit |
| resync_en | input | 1 | Allow edge resynchronization |
| bit_val | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| bit_start_stb | output | 1 | One-clock pulse when a new bit starts |

## Verification
The assertions assume that `hard_sync` is only meaningful while `run_en` is high. They also assume that the configuration holds legal minus-one encodings, so segment lengths stay at least one quantum. The stimulus builds every configuration from real quantum counts, subtracts one before packing, and changes `cfg_word` only during configuration mode, except in the one scenario that tests the freeze. All receive-line edges and the `hard_sync` pulse are placed in the middle of a quantum, away from prescaler wrap clocks, so each expected phase error is unambiguous.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int PRE_W = 10;
  localparam int GAP_W = 4;
  localparam int SJW_W = 2;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;

  // field positions are fixed by the packed word layout
  typedef struct packed {
    logic             triple;
    logic [TS2_W-1:0] ts2_m1;
    logic [TS1_W-1:0] ts1_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [GAP_W-1:0] gap;
    logic [PRE_W-1:0] pre_m1;
  } cbt_cfg_t;

  localparam int CFG_W = $bits(cbt_cfg_t);

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } cbt_phase_e;
endpackage

// File: rtl/cbt_tq_gen.sv
module cbt_tq_gen #(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_m1,
  output logic             tick
);
  logic [PRE_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      div_cnt <= '0;
    end else if (div_cnt == pre_m1) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tick = run && !restart && (div_cnt == pre_m1);
endmodule

// File: rtl/cbt_seg_seq.sv
module cbt_seg_seq
  import cbt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hard_sync,
  input  logic             resync_en,
  input  logic             fall_edge,
  input  logic             tick,
  input  logic [CNT_W-1:0] ts1_len,
  input  logic [CNT_W-1:0] ts2_len,
  input  logic [CNT_W-1:0] sjw_len,
  output logic             sp_hit,
  output logic             sample_stb,
  output logic             bit_start_stb
);
  cbt_phase_e       phase;
  logic [CNT_W-1:0] q_idx;
  logic [CNT_W-1:0] s1_len, s2_len;
  logic             adj_done;

  logic [CNT_W:0]   q_p1, sjw_x, err1, err2, lim1, lim2, s1_sum;
  logic [CNT_W-1:0] s1_nx, s2_nx;
  logic             can_adj, eob;

  always_comb begin
    q_p1    = {1'b0, q_idx} + 1'b1;
    sjw_x   = {1'b0, sjw_len};
    err1    = q_p1;
    err2    = {1'b0, s2_len} - {1'b0, q_idx};
    lim1    = (err1 > sjw_x) ? sjw_x : err1;
    lim2    = (err2 > sjw_x) ? sjw_x : err2;
    can_adj = run && resync_en && fall_edge && !adj_done &&
              !hard_sync && (phase != PH_SYNC);
    s1_sum  = {1'b0, s1_len} + lim1;
    s1_nx   = s1_len;
    s2_nx   = s2_len;
    if (can_adj && phase == PH_SEG1) s1_nx = s1_sum[CNT_W-1:0];
    if (can_adj && phase == PH_SEG2) s2_nx = s2_len - lim2[CNT_W-1:0];
    sp_hit  = tick && (phase == PH_SEG1) && (q_p1 >= {1'b0, s1_nx});
    eob     = tick && (phase == PH_SEG2) && (q_p1 >= {1'b0, s2_nx});
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase         <= PH_SYNC;
      q_idx         <= '0;
      s1_len        <= ts1_len;
      s2_len        <= ts2_len;
      adj_done      <= 1'b0;
      sample_stb    <= 1'b0;
      bit_start_stb <= 1'b0;
    end else begin
      sample_stb    <= sp_hit;
      bit_start_stb <= hard_sync || eob;
      if (hard_sync) begin
        phase    <= PH_SYNC;
        q_idx    <= '0;
        s1_len   <= ts1_len;
        s2_len   <= ts2_len;
        adj_done <= 1'b0;
      end else begin
        s1_len <= s1_nx;
        s2_len <= s2_nx;
        if (can_adj) adj_done <= 1'b1;
        if (tick) begin
          unique case (phase)
            PH_SYNC: begin
              phase <= PH_SEG1;
              q_idx <= '0;
            end
            PH_SEG1: begin
              if (sp_hit) begin
                phase <= PH_SEG2;
                q_idx <= '0;
              end else begin
                q_idx <= q_idx + 1'b1;
              end
            end
            default: begin
              if (eob) begin
                phase    <= PH_SYNC;
                q_idx    <= '0;
                s1_len   <= ts1_len;
                s2_len   <= ts2_len;
                adj_done <= 1'b0;
              end else begin
                q_idx <= q_idx + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler #(
  parameter int HIST_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic sp_hit,
  input  logic rx_s,
  input  logic triple,
  output logic bit_val
);
  logic [HIST_N-1:0] hist;
  logic              vote;

  generate
    if (HIST_N == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (rst || !run) hist <= '1;
        else if (tick)   hist <= rx_s;
      end
    end else begin : g_long
      always_ff @(posedge clk) begin
        if (rst || !run) hist <= '1;
        else if (tick)   hist <= {hist[HIST_N-2:0], rx_s};
      end
    end
  endgenerate

  assign vote = (rx_s & hist[0]) | (rx_s & hist[HIST_N-1]) |
                (hist[0] & hist[HIST_N-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_val <= 1'b1;
    end else if (run && sp_hit) begin
      bit_val <= triple ? vote : rx_s;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int CFG_BITS = CFG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_en,
  input  logic [CFG_BITS-1:0] cfg_word,
  input  logic                rx_line,
  input  logic                hard_sync,
  input  logic                resync_en,
  output logic                bit_val,
  output logic                sample_stb,
  output logic                bit_start_stb
);
  localparam int CNT_W = $clog2((1 << TS1_W) + (1 << SJW_W) + 1);

  cbt_cfg_t         cfg_q;
  logic             rx_q, rx_prev, fall_edge;
  logic             tick, sp_hit;
  logic [CNT_W-1:0] ts1_len, ts2_len, sjw_len;

  always_ff @(posedge clk) begin
    if (rst)          cfg_q <= '0;
    else if (!run_en) cfg_q <= cbt_cfg_t'(cfg_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_q    <= rx_line;
      rx_prev <= rx_q;
    end
  end

  assign fall_edge = rx_prev & ~rx_q;
  assign ts1_len   = CNT_W'(cfg_q.ts1_m1) + CNT_W'(1);
  assign ts2_len   = CNT_W'(cfg_q.ts2_m1) + CNT_W'(1);
  assign sjw_len   = CNT_W'(cfg_q.sjw_m1) + CNT_W'(1);

  cbt_tq_gen #(.PRE_W(PRE_W)) u_tq (
    .clk     (clk),
    .rst     (rst),
    .run     (run_en),
    .restart (hard_sync),
    .pre_m1  (cfg_q.pre_m1),
    .tick    (tick)
  );

  cbt_seg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .run           (run_en),
    .hard_sync     (hard_sync),
    .resync_en     (resync_en),
    .fall_edge     (fall_edge),
    .tick          (tick),
    .ts1_len       (ts1_len),
    .ts2_len       (ts2_len),
    .sjw_len       (sjw_len),
    .sp_hit        (sp_hit),
    .sample_stb    (sample_stb),
    .bit_start_stb (bit_start_stb)
  );

  cbt_sampler #(.HIST_N(2)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .run     (run_en),
    .tick    (tick),
    .sp_hit  (sp_hit),
    .rx_s    (rx_q),
    .triple  (cfg_q.triple),
    .bit_val (bit_val)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import cbt_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     run_en,
  input logic     hard_sync,
  input logic     sample_stb,
  input logic     bit_start_stb,
  input logic     bit_val,
  input cbt_cfg_t cfg_q
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_start_stb));

  // R12
  bitval_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_val) |-> sample_stb);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!sample_stb && !bit_start_stb));

  // R8
  hard_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && hard_sync) |=> bit_start_stb);

  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && $past(run_en)) |-> $stable(cfg_q));
endmodule

bind can_bit_timer cbt_checker u_cbt_chk (
  .clk           (clk),
  .rst           (rst),
  .run_en        (run_en),
  .hard_sync     (hard_sync),
  .sample_stb    (sample_stb),
  .bit_start_stb (bit_start_stb),
  .bit_val       (bit_val),
  .cfg_q         (cfg_q)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [23:0] cfg_word = '0;
  logic        rx_line = 1'b1;
  logic        hard_sync = 1'b0;
  logic        resync_en = 1'b0;
  logic        bit_val, sample_stb, bit_start_stb;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  can_bit_timer dut (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_word(cfg_word),
    .rx_line(rx_line), .hard_sync(hard_sync), .resync_en(resync_en),
    .bit_val(bit_val), .sample_stb(sample_stb), .bit_start_stb(bit_start_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] mk_cfg(int pre, int sjw, int t1, int t2, bit tri3);
    logic [23:0] w;
    w        = '0;
    w[9:0]   = 10'(pre - 1);
    w[15:14] = 2'(sjw - 1);
    w[19:16] = 4'(t1 - 1);
    w[22:20] = 3'(t2 - 1);
    w[23]    = tri3;
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start(output int t);
    do @(negedge clk); while (!bit_start_stb);
    t = cyc;
  endtask

  task automatic wait_sample(output int t);
    do @(negedge clk); while (!sample_stb);
    t = cyc;
  endtask

  task automatic configure(logic [23:0] w);
    @(negedge clk);
    run_en   = 1'b0;
    cfg_word = w;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic t_period(string req, logic [23:0] w, int exp);
    int t0, t1;
    configure(w);
    wait_start(t0);
    wait_start(t1);
    chk(req, t1 - t0, exp);
    wait_start(t0);
    chk(req, t0 - t1, exp);
  endtask

  task automatic t_sample_offset();
    int t0, t1;
    wait_start(t0);
    wait_sample(t1);
    chk("R3 sample offset", t1 - t0, 28);
  endtask

  task automatic t_single_value(logic lvl);
    int t0, t1;
    wait_start(t0);
    rx_line = lvl;
    wait_sample(t1);
    chk("R4 single sample", int'(bit_val), int'(lvl));
    rx_line = 1'b1;
  endtask

  task automatic t_glitch(string req, int from_k, int exp);
    int t0;
    wait_start(t0);
    repeat (from_k) @(posedge clk);
    @(negedge clk) rx_line = 1'b0;
    repeat (28 - from_k) @(posedge clk);
    @(negedge clk);
    chk({req, " strobe"}, int'(sample_stb), 1);
    chk(req, int'(bit_val), exp);
    rx_line = 1'b1;
  endtask

  task automatic t_hold();
    int t0;
    wait_start(t0);
    rx_line = 1'b0;
    wait_sample(t0);
    rx_line = 1'b1;
    repeat (10) @(negedge clk);
    chk("R12 bit_val held between samples", int'(bit_val), 0);
  endtask

  task automatic t_lock();
    int t0, t1;
    configure(mk_cfg(4, 2, 6, 4, 1'b0));
    wait_start(t0);
    cfg_word = mk_cfg(2, 1, 3, 2, 1'b0);
    wait_start(t1);
    wait_start(t0);
    chk("R6 config frozen while running", t0 - t1, 44);
  endtask

  task automatic t_idle();
    int seen = 0;
    @(negedge clk) run_en = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (sample_stb || bit_start_stb) seen++;
    end
    chk("R7 no strobes while idle", seen, 0);
  endtask

  task automatic t_hard_sync();
    int t0, t1, t2;
    wait_start(t0);
    repeat (20) @(posedge clk);
    @(negedge clk) hard_sync = 1'b1;
    @(negedge clk) hard_sync = 1'b0;
    chk("R8 hard sync strobe", int'(bit_start_stb), 1);
    t1 = cyc;
    chk("R8 restart point", t1 - t0, 21);
    wait_sample(t2);
    chk("R8 sample after restart", t2 - t1, 28);
  endtask

  task automatic t_resync(string req, bit en, int k, int exp);
    int t0, t1;
    resync_en = en;
    rx_line   = 1'b1;
    wait_start(t0);
    repeat (k) @(posedge clk);
    @(negedge clk) rx_line = 1'b0;
    wait_start(t1);
    chk(req, t1 - t0, exp);
    rx_line = 1'b1;
    wait_start(t0);
    resync_en = 1'b0;
  endtask

  task automatic t_double_edge();
    int t0, t1;
    resync_en = 1'b1;
    wait_start(t0);
    repeat (4) @(posedge clk);
    @(negedge clk) rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    rx_line = 1'b0;
    wait_start(t1);
    chk("R11 one adjustment per bit", t1 - t0, 48);
    rx_line = 1'b1;
    wait_start(t0);
    resync_en = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset sample_stb", int'(sample_stb), 0);
    chk("R13 reset bit_start_stb", int'(bit_start_stb), 0);
    chk("R13 reset bit_val", int'(bit_val), 1);
    rst = 1'b0;

    t_period("R1 R2 bit period 4x11", mk_cfg(4, 2, 6, 4, 1'b0), 44);
    t_sample_offset();
    t_single_value(1'b0);
    t_single_value(1'b1);
    t_glitch("R4 single sample sees glitch", 24, 0);
    t_hold();
    t_lock();
    t_idle();
    configure(mk_cfg(4, 2, 6, 4, 1'b1));
    t_glitch("R5 majority rejects one low", 24, 1);
    t_glitch("R5 majority of two lows", 20, 0);

    configure(mk_cfg(4, 2, 6, 4, 1'b0));
    t_hard_sync();
    t_resync("R9 lengthen capped by SJW", 1'b1, 12, 52);
    t_resync("R9 lengthen by small error", 1'b1, 4, 48);
    t_resync("R10 shorten segment 2", 1'b1, 28, 36);
    t_resync("R11 edge in sync segment", 1'b1, 1, 44);
    t_resync("R11 resync disabled", 1'b0, 12, 44);
    t_double_edge();

    t_period("R2 minimum segments", mk_cfg(1, 1, 1, 1, 1'b0), 3);
    t_period("R2 maximum segments", mk_cfg(2, 4, 16, 8, 1'b0), 50);
    t_period("R1 prescaler 64", mk_cfg(64, 1, 1, 1, 1'b0), 192);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule